// File: doc/BRIEF.md
# Misaligned Access Bus Cycle Splitter

The splitter takes one load or store from a CPU data port (byte, halfword or word, at any byte address) and turns it into the shortest legal series of cycles on a 16-bit data bus. For each cycle it drives the address, the cycle size, two byte-lane enables and the write data. For a load it collects the returned bytes and presents the result, right-justified, in one word. A per-request select runs the external side as an 8-bit bus instead. In that mode every access becomes single-byte cycles on the lower lane.

Byte order is little-endian. A split request always starts with its lowest-addressed part and moves upward. On the 16-bit bus an unaligned word becomes byte, halfword, byte. It is not rejected, and it is not cut into two equal halves. Each bus cycle waits for a ready handshake. A one-cycle done pulse marks the end of the request.

Top module: `bus_cycle_splitter`

## Requirements
- R1: A request is taken when `req_valid_i` is high and `busy_o` is low. `busy_o` is high from the next cycle until the final bus cycle completes. Request inputs presented while `busy_o` is high are ignored.
- R2: Size codes are 0 = byte, 1 = halfword, 2 or 3 = word. Bus cycles go to ascending addresses starting at the request address, and byte k of `req_wdata_i` (bits 8k+7..8k) belongs to address base+k.
- R3: A byte request is always exactly one byte cycle.
- R4: On the 16-bit bus, a halfword at an even address is one halfword cycle. A word whose address has its low two bits equal to 00 is two halfword cycles, at base and then base+2.
- R5: On the 16-bit bus, a halfword at an odd address is two byte cycles, at base and then base+1.
- R6: On the 16-bit bus, a word whose low two address bits are 01 or 11 is a byte cycle at base, then a halfword cycle at base+1, then a byte cycle at base+3.
- R7: On the 16-bit bus, a word whose low two address bits are 10 is two halfword cycles, at base and then base+2.
- R8: With `req_narrow_i` = 1, a request of n bytes is n byte cycles at base..base+n-1, each with `bus_be_o` = 01.
- R9: A halfword cycle has `bus_half_o` = 1 and `bus_be_o` = 11, and its write data is {byte at address+1, byte at address}. A byte cycle on the 16-bit bus has `bus_be_o` = 01 at an even address and 10 at an odd one. In every byte cycle the write byte is placed on both lanes.
- R10: A bus cycle holds address, size, lanes and data until `bus_ready_i` is high at a clock edge. In the cycle after the final ready, `done_o` is high for exactly one cycle and `busy_o` is low.
- R11: `rdata_o` shows the read result from the done cycle until the next done. Byte k of the result comes from the enabled lane of the cycle that covered base+k. Bytes beyond the request size are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_write_i | input | 1 | 1 store, 0 load |
| req_wdata_i | input | 32 | Store data, right-justified |
| req_narrow_i | input | 1 | 1 selects 8-bit external bus |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Assembled load data |
| bus_valid_o | output | 1 | Bus cycle active |
| bus_addr_o | output | ADDR_W | Byte address of current cycle |
| bus_half_o | output | 1 | 1 halfword cycle, 0 byte cycle |
| bus_be_o | output | 2 | Lane enables {upper, lower} |
| bus_we_o | output | 1 | Write cycle |
| bus_wdata_o | output | 16 | Write data lanes |
| bus_rdata_i | input | 16 | Read data lanes |
| bus_ready_i | input | 1 | Current cycle completes at this edge |

## Verification
Directed requests cover every size at each of the four low address values, on both bus widths. These tell apart the byte-half-byte split of an odd word, the half-half split of a word at offset 2, and the byte-per-byte path of the narrow bus. Random requests with random ready stalls and random read lanes show that cycles are held correctly and that each returned byte lands in its proper result position. One directed case presents a second request while busy, to show it is ignored.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANE_W = 16;
  localparam int unsigned NBYTES = DATA_W / 8;
  localparam int unsigned OFF_W  = $clog2(NBYTES) + 1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD3 = 2'd3
  } size_e;

  function automatic logic [OFF_W-1:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return OFF_W'(1);
      SZ_HALF: return OFF_W'(2);
      default: return OFF_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/bcs_planner.sv
module bcs_planner
  import bcs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              narrow_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              half_o,
  output logic [OFF_W-1:0]  step_o,
  output logic              last_o
);
  logic [OFF_W-1:0] total;
  logic [OFF_W-1:0] remain;

  always_comb begin
    total  = size_bytes(size_i);
    remain = total - off_i;
    addr_o = base_i + ADDR_W'(off_i);
    // halfword only when address is even and two bytes remain
    half_o = !narrow_i && !addr_o[0] && (remain >= OFF_W'(2));
    step_o = half_o ? OFF_W'(2) : OFF_W'(1);
    last_o = (step_o == remain);
  end
endmodule

// File: rtl/bcs_lane_mux.sv
module bcs_lane_mux
  import bcs_pkg::*;
(
  input  logic              half_i,
  input  logic              narrow_i,
  input  logic              addr0_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANE_W-1:0] rdata_i,
  output logic [1:0]        be_o,
  output logic [LANE_W-1:0] wdata_o,
  output logic [7:0]        rbyte0_o,
  output logic [7:0]        rbyte1_o
);
  logic [7:0] wb0;
  logic [7:0] wb1;
  logic       upper;

  always_comb begin
    wb0   = wdata_i[8*off_i[1:0] +: 8];
    wb1   = wdata_i[8*(off_i[1:0] + 2'd1) +: 8];
    upper = addr0_i && !narrow_i;
    if (half_i) begin
      be_o     = 2'b11;
      wdata_o  = {wb1, wb0};
      rbyte0_o = rdata_i[7:0];
      rbyte1_o = rdata_i[15:8];
    end else begin
      be_o     = upper ? 2'b10 : 2'b01;
      wdata_o  = {wb0, wb0};
      rbyte0_o = upper ? rdata_i[15:8] : rdata_i[7:0];
      rbyte1_o = 8'h00;
    end
  end
endmodule

// File: rtl/bus_cycle_splitter.sv
module bus_cycle_splitter
  import bcs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_narrow_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_valid_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_half_o,
  output logic [1:0]        bus_be_o,
  output logic              bus_we_o,
  output logic [LANE_W-1:0] bus_wdata_o,
  input  logic [LANE_W-1:0] bus_rdata_i,
  input  logic              bus_ready_i
);
  logic              busy_q, done_q, narrow_q, we_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] wdata_q, acc_q, rdata_q, acc_d;
  logic [OFF_W-1:0]  off_q, step;
  logic              last, half, accept, adv;
  logic [ADDR_W-1:0] cur_addr;
  logic [7:0]        rb0, rb1;

  assign accept = req_valid_i && !busy_q;
  assign adv    = busy_q && bus_ready_i;

  bcs_planner #(.ADDR_W(ADDR_W)) u_planner (
    .base_i  (base_q),
    .size_i  (size_q),
    .off_i   (off_q),
    .narrow_i(narrow_q),
    .addr_o  (cur_addr),
    .half_o  (half),
    .step_o  (step),
    .last_o  (last)
  );

  bcs_lane_mux u_lanes (
    .half_i  (half),
    .narrow_i(narrow_q),
    .addr0_i (cur_addr[0]),
    .off_i   (off_q),
    .wdata_i (wdata_q),
    .rdata_i (bus_rdata_i),
    .be_o    (bus_be_o),
    .wdata_o (bus_wdata_o),
    .rbyte0_o(rb0),
    .rbyte1_o(rb1)
  );

  for (genvar k = 0; k < NBYTES; k++) begin : g_acc
    always_comb begin
      if (adv && (off_q == OFF_W'(k)))
        acc_d[8*k +: 8] = rb0;
      else if (adv && half && (off_q + OFF_W'(1) == OFF_W'(k)))
        acc_d[8*k +: 8] = rb1;
      else
        acc_d[8*k +: 8] = acc_q[8*k +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      narrow_q <= 1'b0;
      we_q     <= 1'b0;
      base_q   <= '0;
      size_q   <= '0;
      wdata_q  <= '0;
      acc_q    <= '0;
      rdata_q  <= '0;
      off_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        narrow_q <= req_narrow_i;
        we_q     <= req_write_i;
        base_q   <= req_addr_i;
        size_q   <= req_size_i;
        wdata_q  <= req_wdata_i;
        acc_q    <= '0;
        off_q    <= '0;
      end else if (adv) begin
        acc_q <= acc_d;
        off_q <= off_q + step;
        if (last) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          rdata_q <= acc_d;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign bus_valid_o = busy_q;
  assign bus_addr_o  = cur_addr;
  assign bus_half_o  = half;
  assign bus_we_o    = we_q;
endmodule

// File: rtl/bus_cycle_splitter_chk.sv
module bus_cycle_splitter_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              bus_valid_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_half_o,
  input logic [1:0]        bus_be_o,
  input logic              bus_ready_i,
  input logic              narrow_q
);
  a_r10_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_addr_o)
      && $stable(bus_be_o) && $stable(bus_half_o));

  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !bus_valid_o);

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_half_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_half_o |-> !bus_addr_o[0] && bus_be_o == 2'b11);

  a_r9_byte_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_half_o && !narrow_q |-> bus_be_o == {bus_addr_o[0], !bus_addr_o[0]});

  a_r8_narrow_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && narrow_q |-> !bus_half_o && bus_be_o == 2'b01);
endmodule

bind bus_cycle_splitter bus_cycle_splitter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .bus_valid_o(bus_valid_o),
  .bus_addr_o (bus_addr_o),
  .bus_half_o (bus_half_o),
  .bus_be_o   (bus_be_o),
  .bus_ready_i(bus_ready_i),
  .narrow_q   (narrow_q)
);

// File: tb/bus_cycle_splitter_bench.sv
module bus_cycle_splitter_bench;
  localparam int AW = 32;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          req_valid_i = 1'b0, req_write_i = 1'b0, req_narrow_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [1:0]    req_size_i = '0;
  logic [31:0]   req_wdata_i = '0;
  logic          busy_o, done_o, bus_valid_o, bus_half_o, bus_we_o;
  logic [31:0]   rdata_o;
  logic [AW-1:0] bus_addr_o;
  logic [1:0]    bus_be_o;
  logic [15:0]   bus_wdata_o;
  logic [15:0]   bus_rdata_i = '0;
  logic          bus_ready_i = 1'b0;

  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  bus_cycle_splitter #(.ADDR_W(AW)) u_bus_cycle_splitter (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected split from the requirement tables: number of cycles, offset and length of cycle i
  function automatic int n_cycles(input logic [1:0] a, input logic [1:0] sz, input bit nar);
    int nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (nar || sz == 0) return nar ? nb : 1;
    if (sz == 1) return a[0] ? 2 : 1;
    return a[0] ? 3 : 2;
  endfunction

  function automatic void piece(input logic [1:0] a, input logic [1:0] sz, input bit nar,
                                input int i, output int off, output int len);
    if (nar || sz == 0) begin off = i; len = 1; end
    else if (sz == 1) begin
      if (a[0]) begin off = i; len = 1; end
      else begin off = 0; len = 2; end
    end else if (a[0]) begin
      case (i) 0: begin off = 0; len = 1; end
               1: begin off = 1; len = 2; end
               default: begin off = 3; len = 1; end
      endcase
    end else begin off = 2 * i; len = 2; end
  endfunction

  function automatic string rtag(input logic [1:0] a, input logic [1:0] sz, input bit nar);
    if (nar) return "R8";
    if (sz == 0) return "R3";
    if (sz == 1) return a[0] ? "R5" : "R4";
    if (a[0]) return "R6";
    return a[1] ? "R7" : "R4";
  endfunction

  task automatic run_req(input logic [AW-1:0] addr, input logic [1:0] sz, input bit wr,
                         input logic [31:0] wd, input bit nar, input bit poke);
    int n = n_cycles(addr[1:0], sz, nar);
    int idx = 0, guard = 0, off, len, lane;
    logic [31:0] exp_rd = '0;
    logic [AW-1:0] ea;
    logic [7:0] b0, b1;
    string tg = rtag(addr[1:0], sz, nar);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = addr; req_size_i = sz;
    req_write_i = wr; req_wdata_i = wd; req_narrow_i = nar;
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;
    while (idx < n && guard < 200) begin
      @(negedge clk_i);
      guard++;
      if (poke) begin
        req_valid_i = (guard == 1); req_addr_i = ~addr; req_size_i = 2'd0;
        req_write_i = ~wr; req_narrow_i = ~nar; req_wdata_i = ~wd;
      end
      piece(addr[1:0], sz, nar, idx, off, len);
      ea = addr + AW'(off);
      b0 = wd[8*off +: 8];
      b1 = wd[8*((off + 1) % 4) +: 8];
      check(busy_o && bus_valid_o, "R1", "busy/valid", {busy_o, bus_valid_o}, 32'h3);
      check(bus_addr_o == ea, tg, "addr (R2)", bus_addr_o, ea);
      check(bus_half_o == (len == 2), tg, "size", bus_half_o, (len == 2));
      check(bus_we_o == wr, "R1", "we", bus_we_o, wr);
      if (len == 2) begin
        check(bus_be_o == 2'b11, "R9", "be half", bus_be_o, 2'b11);
        check(bus_wdata_o == {b1, b0}, "R9", "wdata half", bus_wdata_o, {b1, b0});
      end else begin
        lane = nar ? 0 : int'(ea[0]);
        check(bus_be_o == (lane ? 2'b10 : 2'b01), nar ? "R8" : "R9", "be byte",
              bus_be_o, lane ? 2'b10 : 2'b01);
        check(bus_wdata_o == {b0, b0}, "R9", "wdata byte", bus_wdata_o, {b0, b0});
      end
      bus_ready_i = ($urandom % 3) != 0;
      bus_rdata_i = 16'($urandom);
      if (bus_ready_i) begin
        if (len == 2) begin
          exp_rd[8*off +: 8] = bus_rdata_i[7:0];
          exp_rd[8*(off + 1) +: 8] = bus_rdata_i[15:8];
        end else begin
          lane = nar ? 0 : int'(ea[0]);
          exp_rd[8*off +: 8] = lane ? bus_rdata_i[15:8] : bus_rdata_i[7:0];
        end
        idx++;
      end
    end
    if (poke) req_valid_i = 1'b0;
    @(negedge clk_i);
    bus_ready_i = 1'b0;
    check(done_o === 1'b1, "R10", "done pulse", done_o, 1);
    check(busy_o === 1'b0, "R10", "busy low at done", busy_o, 0);
    check(rdata_o == exp_rd, "R11", "read data", rdata_o, exp_rd);
    @(negedge clk_i);
    check(done_o === 1'b0 && busy_o === 1'b0, "R10", "done one cycle", {done_o, busy_o}, 0);
    check(rdata_o == exp_rd, "R11", "read data held", rdata_o, exp_rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    check(busy_o === 1'b0 && bus_valid_o === 1'b0 && done_o === 1'b0, "R1", "reset outputs",
          {busy_o, bus_valid_o, done_o}, 0);
    check(rdata_o === 32'h0, "R11", "reset rdata", rdata_o, 0);
    rst_ni = 1'b1;
    // directed: every size at every low address, both widths, loads and stores
    for (int nar = 0; nar < 2; nar++)
      for (int sz = 0; sz < 3; sz++)
        for (int a = 0; a < 4; a++)
          for (int wr = 0; wr < 2; wr++)
            run_req(32'h0000_1000 + 32'(a), 2'(sz), wr[0], 32'hA1B2_C3D4, nar[0], 1'b0);
    // size code 3 acts as word (R2), address carry across a 4-byte boundary (R6)
    run_req(32'h0000_20FF, 2'd3, 1'b0, 32'h1122_3344, 1'b0, 1'b0);
    // request inputs while busy are ignored (R1)
    run_req(32'h0000_3001, 2'd2, 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b1);
    run_req(32'h0000_3002, 2'd1, 1'b0, 32'h0BAD_F00D, 1'b1, 1'b1);
    // random mix
    for (int t = 0; t < 400; t++)
      run_req(32'($urandom), 2'($urandom), 1'($urandom), $urandom, 1'($urandom), 1'($urandom % 8 == 0));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule